// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry, Overflow and Condition Flags

This block is the combinational add/subtract datapath of a RISC integer pipeline. It takes two 32-bit operands, the architectural carry flag, the overflow and sticky summary-overflow flags, and an opcode. It returns the sum, the new carry, the new overflow and summary-overflow values, and a 4-bit condition field for instructions that record their result. Decode, register access and immediate extraction happen elsewhere. An immediate arrives on operand `b` already extended to 32 bits.

Every opcode reduces to one addition `x + y + k`. The operand router selects `x`, `y` and the one-bit carry term `k`. The subtract forms feed the inverted first operand into the adder. The extended forms use the incoming carry as `k`, and they put all-ones or zero in the second addend. Carry is not taken from a 33rd adder bit. It is derived by comparing the result, unsigned, against a reference operand. The comparison accounts for the carry term, so the same rule serves the plain, extended and immediate forms.

Overflow updates are gated by an overflow-enable input. The summary-overflow bit is sticky: it collects every enabled overflow and drops only on an explicit clear. The condition field reports negative, positive or zero in its upper three bits, and carries the updated summary-overflow in bit 0.

Top module: `int_addsub_unit`

## Requirements
- R1: Opcode 0 (plain add) gives `res = a + b`. Opcode 1 (add, carrying) gives the same result. Opcode 2 (add, extended) gives `res = a + b + ca_in`. All results are modulo 2^32.
- R2: Opcode 5 (subtract-from) gives `res = b + ~a + 1`. Opcode 6 (subtract-from, extended) gives `res = b + ~a + ca_in`. Opcode 9 (subtract-from, immediate, carrying) gives `res = b + ~a + 1`.
- R3: The minus-one and zero forms work as follows. Opcode 3 gives `a + ca_in + 0xFFFFFFFF`. Opcode 4 gives `a + ca_in`. Opcode 7 gives `~a + ca_in + 0xFFFFFFFF`. Opcode 8 gives `~a + ca_in`.
- R4: For opcodes 1, 2, 3, 4, 6, 7, 8 and 9, `ca_out` equals the carry out of bit 31 of the full addition `x + y + k`. This includes the case where the result equals the reference operand with a carry term of 1. For opcodes 0 and 5, `ca_out` equals `ca_in`.
- R5: When `oe` is 1 and the opcode is not 9, `ov_out` is 1 exactly when the two addends share a sign bit and the result's sign bit differs from it. Otherwise `ov_out` is 0.
- R6: When `oe` is 0, or the opcode is 9, `ov_out` equals `ov_in`, and `so_out` equals `so_in` unless `so_clr` is 1.
- R7: `so_out` is sticky. It is 1 whenever `so_in` is 1 and `so_clr` is 0, and it is also 1 whenever an enabled overflow occurs. With `so_clr` set and no enabled overflow, `so_out` is 0.
- R8: When `rc` is 1, the condition field `cr_out` is built as follows. Bit 3 is set for a negative result (bit 31 set). Bit 2 is set for a positive nonzero result. Bit 1 is set for a zero result. Bit 0 equals `so_out`. Exactly one of bits 3..1 is set.
- R9: When `rc` is 0, `cr_out` is 0.
- R10: Opcodes 10 to 15 behave exactly like opcode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code, encodings per R1 to R3 and R10 |
| a | input | 32 | First operand (the subtrahend for subtract forms) |
| b | input | 32 | Second operand or ready-made immediate |
| ca_in | input | 1 | Current carry flag |
| ov_in | input | 1 | Current overflow flag |
| so_in | input | 1 | Current sticky summary-overflow flag |
| so_clr | input | 1 | Clears summary-overflow before this operation's update |
| oe | input | 1 | Overflow-enable for this operation |
| rc | input | 1 | Record form: produce the condition field |
| res | output | 32 | Result |
| ca_out | output | 1 | New carry flag |
| ov_out | output | 1 | New overflow flag |
| so_out | output | 1 | New summary-overflow flag |
| cr_out | output | 4 | Condition field |

## Verification
Each opcode is driven at its unsigned wrap points: all-ones plus one, a zero operand, equal operands, and a result exactly equal to the reference with carry-in set. These points separate a comparison-based carry from an off-by-one comparison and from an inverted carry term. Signed boundaries (0x7FFFFFFF, 0x80000000) are driven with the overflow enable both on and off, which shows that only enabled, permitted opcodes touch the overflow flags. Sticky summary-overflow and its clear are tried in all four input combinations. A stream of pseudo-random operands over every opcode, with random flag inputs, compares all outputs against a 33-bit reference sum and a wide signed sum.

// File: rtl/int_addsub_pkg.sv
package int_addsub_pkg;

    typedef enum logic [3:0] {
        OPC_ADD    = 4'd0,
        OPC_ADDC   = 4'd1,
        OPC_ADDE   = 4'd2,
        OPC_ADDME  = 4'd3,
        OPC_ADDZE  = 4'd4,
        OPC_SUBF   = 4'd5,
        OPC_SUBFE  = 4'd6,
        OPC_SUBFME = 4'd7,
        OPC_SUBFZE = 4'd8,
        OPC_SUBFIC = 4'd9
    } opc_e;

    // carry derivation rule selected by the operand router
    typedef enum logic [1:0] {
        CK_KEEP = 2'd0,   // carry flag passes through
        CK_LT   = 2'd1,   // res < ref, or k and res == ref
        CK_LE   = 2'd2,   // res <= ref
        CK_NZ   = 2'd3    // x != 0 or k (all-ones addend)
    } carry_rule_e;

    localparam int CR_W = 4;

endpackage

// File: rtl/addsub_route.sv
module addsub_route
    import int_addsub_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ca_in,
    output logic [W-1:0] x,
    output logic [W-1:0] y,
    output logic         k,
    output logic [W-1:0] ref_op,
    output carry_rule_e  rule,
    output logic         oe_ok
);

    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] ZERO = '0;

    always_comb begin
        x      = a;
        y      = b;
        k      = 1'b0;
        ref_op = a;
        rule   = CK_KEEP;
        oe_ok  = 1'b1;
        case (op)
            OPC_ADDC: begin
                rule = CK_LT;
            end
            OPC_ADDE: begin
                k    = ca_in;
                rule = CK_LT;
            end
            OPC_ADDME: begin
                y    = ONES;
                k    = ca_in;
                rule = CK_NZ;
            end
            OPC_ADDZE: begin
                y    = ZERO;
                k    = ca_in;
                rule = CK_LT;
            end
            OPC_SUBF: begin
                x = b;
                y = ~a;
                k = 1'b1;
            end
            OPC_SUBFE: begin
                x      = b;
                y      = ~a;
                k      = ca_in;
                ref_op = b;
                rule   = CK_LT;
            end
            OPC_SUBFME: begin
                x      = ~a;
                y      = ONES;
                k      = ca_in;
                ref_op = ~a;
                rule   = CK_NZ;
            end
            OPC_SUBFZE: begin
                x      = ~a;
                y      = ZERO;
                k      = ca_in;
                ref_op = ~a;
                rule   = CK_LT;
            end
            OPC_SUBFIC: begin
                x      = b;
                y      = ~a;
                k      = 1'b1;
                ref_op = b;
                rule   = CK_LE;
                oe_ok  = 1'b0;
            end
            default: begin
                // plain add: defaults already selected
            end
        endcase
    end

endmodule

// File: rtl/addsub_carry.sv
module addsub_carry
    import int_addsub_pkg::*;
#(
    parameter int W = 32
) (
    input  carry_rule_e  rule,
    input  logic [W-1:0] x,
    input  logic [W-1:0] res,
    input  logic [W-1:0] ref_op,
    input  logic         k,
    input  logic         ca_in,
    output logic         ca_out
);

    logic below;
    logic equal;

    assign below = (res < ref_op);
    assign equal = (res == ref_op);

    always_comb begin
        unique case (rule)
            CK_LT:   ca_out = below | (k & equal);
            CK_LE:   ca_out = below | equal;
            CK_NZ:   ca_out = (|x) | k;
            default: ca_out = ca_in;
        endcase
    end

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import int_addsub_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    x,
    input  logic [W-1:0]    y,
    input  logic [W-1:0]    res,
    input  logic            oe,
    input  logic            oe_ok,
    input  logic            rc,
    input  logic            ov_in,
    input  logic            so_in,
    input  logic            so_clr,
    output logic            ov_out,
    output logic            so_out,
    output logic [CR_W-1:0] cr_out
);

    localparam int MSB = W - 1;

    logic ov_raw;
    logic oe_eff;
    logic so_base;
    logic [2:0] sign_class;

    assign ov_raw  = (x[MSB] == y[MSB]) && (res[MSB] != x[MSB]);
    assign oe_eff  = oe & oe_ok;
    assign so_base = so_clr ? 1'b0 : so_in;

    assign ov_out = oe_eff ? ov_raw : ov_in;
    assign so_out = so_base | (oe_eff & ov_raw);

    always_comb begin
        if (res[MSB])
            sign_class = 3'b100;
        else if (|res)
            sign_class = 3'b010;
        else
            sign_class = 3'b001;
    end

    assign cr_out = rc ? {sign_class, so_out} : '0;

endmodule

// File: rtl/int_addsub_unit.sv
module int_addsub_unit
    import int_addsub_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]      op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            ca_in,
    input  logic            ov_in,
    input  logic            so_in,
    input  logic            so_clr,
    input  logic            oe,
    input  logic            rc,
    output logic [W-1:0]    res,
    output logic            ca_out,
    output logic            ov_out,
    output logic            so_out,
    output logic [CR_W-1:0] cr_out
);

    logic [W-1:0] x_s;
    logic [W-1:0] y_s;
    logic [W-1:0] ref_s;
    logic         k_s;
    logic         oe_ok_s;
    carry_rule_e  rule_s;

    addsub_route #(.W(W)) route_i (
        .op(op), .a(a), .b(b), .ca_in(ca_in),
        .x(x_s), .y(y_s), .k(k_s), .ref_op(ref_s),
        .rule(rule_s), .oe_ok(oe_ok_s)
    );

    assign res = x_s + y_s + {{(W-1){1'b0}}, k_s};

    addsub_carry #(.W(W)) carry_i (
        .rule(rule_s), .x(x_s), .res(res), .ref_op(ref_s),
        .k(k_s), .ca_in(ca_in), .ca_out(ca_out)
    );

    addsub_flags #(.W(W)) flags_i (
        .x(x_s), .y(y_s), .res(res), .oe(oe), .oe_ok(oe_ok_s),
        .rc(rc), .ov_in(ov_in), .so_in(so_in), .so_clr(so_clr),
        .ov_out(ov_out), .so_out(so_out), .cr_out(cr_out)
    );

    // checks between port inputs and the separately built outputs
    always_comb begin
        if (op == OPC_ADD || op == OPC_SUBF)
            a_r4_carry_held : assert (ca_out == ca_in);
        if (!oe)
            a_r6_flags_held : assert (ov_out == ov_in && so_out == (so_in & ~so_clr));
        if (so_in && !so_clr)
            a_r7_sticky : assert (so_out);
        if (rc)
            a_r8_one_class : assert ($countones(cr_out[3:1]) == 1 && cr_out[0] == so_out);
        if (rc && res == '0)
            a_r8_zero_class : assert (cr_out[1]);
        if (!rc)
            a_r9_no_record : assert (cr_out == '0);
    end

endmodule

// File: tb/int_addsub_unit_tb.sv
module int_addsub_unit_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [3:0]  op = '0;
    logic [31:0] a = '0, b = '0;
    logic ca_in = 0, ov_in = 0, so_in = 0, so_clr = 0, oe = 0, rc = 0;
    logic [31:0] res;
    logic ca_out, ov_out, so_out;
    logic [3:0] cr_out;

    int_addsub_unit dut_i (
        .op(op), .a(a), .b(b), .ca_in(ca_in), .ov_in(ov_in), .so_in(so_in),
        .so_clr(so_clr), .oe(oe), .rc(rc), .res(res), .ca_out(ca_out),
        .ov_out(ov_out), .so_out(so_out), .cr_out(cr_out)
    );

    typedef struct {
        logic [31:0] r;
        logic c, v, s;
        logic [3:0] cr;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model: 33-bit unsigned sum and wide signed sum
    task automatic drive(input logic [3:0] o, input logic [31:0] av, input logic [31:0] bv,
                         input logic ci, input logic vi, input logic si, input logic cl,
                         input logic e, input logic r, input string tag);
        logic [31:0] x, y;
        logic kk, carry_op, oe_ok, v, s;
        logic [32:0] us;
        longint ss;
        exp_t it;
        x = av; y = bv; kk = 0; carry_op = 1; oe_ok = 1;
        case (o)
            4'd1: ;
            4'd2: kk = ci;
            4'd3: begin y = 32'hFFFF_FFFF; kk = ci; end
            4'd4: begin y = 32'h0; kk = ci; end
            4'd5: begin x = bv; y = ~av; kk = 1; carry_op = 0; end
            4'd6: begin x = bv; y = ~av; kk = ci; end
            4'd7: begin x = ~av; y = 32'hFFFF_FFFF; kk = ci; end
            4'd8: begin x = ~av; y = 32'h0; kk = ci; end
            4'd9: begin x = bv; y = ~av; kk = 1; oe_ok = 0; end
            default: carry_op = 0;
        endcase
        us = {1'b0, x} + {1'b0, y} + {32'h0, kk};
        ss = longint'($signed(x)) + longint'($signed(y)) + longint'(kk);
        v  = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        it.r = us[31:0];
        it.c = carry_op ? us[32] : ci;
        it.v = (e && oe_ok) ? v : vi;
        s = (si && !cl) || (e && oe_ok && v);
        it.s = s;
        if (!r) it.cr = 4'h0;
        else if (us[31]) it.cr = {3'b100, s};
        else if (us[31:0] != 0) it.cr = {3'b010, s};
        else it.cr = {3'b001, s};
        it.tag = tag;
        @(posedge clk);
        #1;
        op = o; a = av; b = bv; ca_in = ci; ov_in = vi; so_in = si;
        so_clr = cl; oe = e; rc = r;
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            n_chk++;
            if (res !== it.r || ca_out !== it.c || ov_out !== it.v ||
                so_out !== it.s || cr_out !== it.cr) begin
                n_bad++;
                $display("FAIL %s: got res=%h ca=%b ov=%b so=%b cr=%h exp res=%h ca=%b ov=%b so=%b cr=%h",
                         it.tag, res, ca_out, ov_out, so_out, cr_out,
                         it.r, it.c, it.v, it.s, it.cr);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        // idle inputs: zero everything
        drive(4'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");
        // R1
        drive(4'd0, 32'h1234_5678, 32'h1111_1111, 1, 0, 0, 0, 0, 0, "R1 add");
        drive(4'd1, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, 0, 0, "R1 R4 addc wrap");
        drive(4'd2, 32'h5, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, 0, "R1 R4 adde equal ref");
        drive(4'd2, 32'hFFFF_FFFF, 32'h0, 1, 0, 0, 0, 0, 0, "R1 R4 adde wrap");
        // R2
        drive(4'd5, 32'h3, 32'h5, 0, 0, 0, 0, 0, 0, "R2 subf");
        drive(4'd6, 32'h3, 32'h3, 1, 0, 0, 0, 0, 1, "R2 R4 subfe equal");
        drive(4'd6, 32'h0, 32'h5, 0, 0, 0, 0, 0, 0, "R2 R4 subfe a0");
        drive(4'd9, 32'h0, 32'h7, 0, 0, 0, 0, 0, 0, "R2 R4 subfic a0");
        drive(4'd9, 32'h5, 32'h3, 1, 0, 0, 0, 0, 0, "R2 R4 subfic borrow");
        drive(4'd9, 32'h9, 32'h9, 0, 0, 0, 0, 0, 1, "R2 R4 subfic equal");
        // R3
        drive(4'd3, 32'h0, 32'h0, 0, 0, 0, 0, 0, 0, "R3 R4 addme zero");
        drive(4'd3, 32'h8000_0000, 0, 0, 0, 0, 0, 1, 0, "R3 R5 addme ov");
        drive(4'd4, 32'h7FFF_FFFF, 0, 1, 0, 0, 0, 1, 0, "R3 R5 addze ov");
        drive(4'd7, 32'h0, 0, 1, 0, 0, 0, 0, 0, "R3 subfme");
        drive(4'd8, 32'h0, 0, 1, 0, 0, 0, 0, 1, "R3 R4 subfze wrap");
        // R5 / R6
        drive(4'd0, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 1, 1, "R5 add ov");
        drive(4'd0, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 0, 0, "R6 oe off");
        drive(4'd0, 32'h1, 32'h1, 0, 1, 1, 0, 0, 0, "R6 flags held");
        drive(4'd9, 32'h1, 32'h8000_0000, 0, 0, 0, 0, 1, 0, "R6 subfic ignores oe");
        drive(4'd5, 32'h1, 32'h8000_0000, 0, 0, 0, 0, 1, 0, "R5 subf ov");
        // R7
        drive(4'd0, 32'h1, 32'h1, 0, 0, 1, 0, 1, 1, "R7 sticky kept");
        drive(4'd0, 32'h1, 32'h1, 0, 0, 1, 1, 1, 1, "R7 cleared");
        drive(4'd0, 32'h7FFF_FFFF, 32'h1, 0, 0, 1, 1, 1, 1, "R7 clear then set");
        // R8
        drive(4'd5, 32'h4, 32'h4, 0, 0, 0, 0, 0, 1, "R8 zero");
        drive(4'd0, 32'h8000_0000, 32'h0, 0, 0, 1, 0, 0, 1, "R8 negative");
        drive(4'd0, 32'h2, 32'h3, 0, 0, 0, 0, 0, 1, "R8 positive");
        // R10
        drive(4'd12, 32'hFFFF_FFFF, 32'h2, 1, 0, 0, 0, 1, 1, "R10 spare opcode");
        drive(4'd15, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 1, 0, "R10 spare ov");
        // mixed stream
        lf = 32'hACE1_2357;
        for (int i = 0; i < 120; i++) begin
            logic [31:0] av, bv;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            av = lf;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            bv = (i % 4 == 0) ? av : lf;
            drive(4'(i % 11), av, bv, lf[0], lf[1], lf[2], lf[3], lf[4], lf[5],
                  "R1 R2 R3 R4 R5 R8 mixed");
        end
        @(posedge clk);
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule